// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

This block collects 32 raw interrupt lines and presents them to software through a small word-addressed register bus. Each line is brought into the clock domain through a two-stage synchroniser. It can then be treated as a level or an edge event, with either sense. Detected events are held in a pending register that software clears by writing ones.

An enable mask selects which pending sources are allowed to reach the two interrupt outputs. A per-source class bit steers each enabled source to either the normal output or the critical output. A level source stays pending for as long as its line is at the active level. Any attempt to clear it during that time is overridden, whether or not the source is enabled.

Source number n always occupies register bit 31−n, so source 0 is the most significant bit of every per-source register. Reads are registered: the data for a read strobe appears on the read-data port after the clock edge that samples the strobe.

Top module: `irqCtrlTop`

## Requirements
- R1: Source n (port bit irqIn[n]) occupies bit 31−n of the pending, enable, class, polarity, trigger and masked-pending registers.
- R2: After reset, enable, class and trigger read as zero (all disabled, all level, all normal), polarity reads all ones (active-high), and pending and the spare storage word read zero.
- R3: A level source (trigger bit 0) sets its pending bit while its synchronised input is at the active level: high when its polarity bit is 1, low when it is 0.
- R4: An edge source (trigger bit 1) sets its pending bit on a rising input edge when polarity is 1 and on a falling edge when polarity is 0; the bit then stays set until cleared.
- R5: Writing the pending register (offset 0x0) clears every bit written as 1 and leaves bits written as 0 unchanged; an edge source clears even while its input is still held active.
- R6: A clear of a level source's pending bit has no effect while its input is still active, whether the source is enabled or not.
- R7: Pending bits latch regardless of enable; offset 0x6 reads pending AND enable and reads zero when no enabled source is pending.
- R8: The normal output is the OR of masked-pending bits whose class bit is 0; the critical output is the OR of those whose class bit is 1.
- R9: An input change present at clock edge k is reflected in the pending register, and in the outputs, after edge k+2 and not before.
- R10: Enable (0x2), class (0x3), polarity (0x4) and trigger (0x5) read back the last value written; read data is valid after the edge that samples the read strobe.
- R11: Offset 0x8 is a read/write storage word; offset 0x7 always reads zero and ignores writes; every unmapped offset reads zero.
- R12: Writing the polarity register does not by itself create an edge event on an edge source whose input is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqIn | input | NUM_SRC | Raw interrupt lines, bit n is source n |
| busAddr | input | ADDR_W | Register word offset |
| busWrData | input | DATA_W | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdData | output | DATA_W | Registered read data |
| irqNonCrit | output | 1 | Normal-class interrupt request |
| irqCrit | output | 1 | Critical-class interrupt request |

## Verification
The bench builds the block with its default parameters: 32 sources, a 32-bit data bus and a 4-bit address. At that size every source can be swept one at a time through all four trigger/polarity combinations. For each source the bench checks the exact bit position, the blocked and successful clears, and steering to each output class. The bench predicts every value from shifts of a single one, and checks the two-cycle synchroniser latency at the output pins cycle by cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [2:0] {
    RSEL_NONE   = 3'd0,
    RSEL_STATUS = 3'd1,
    RSEL_ENABLE = 3'd2,
    RSEL_CLASS  = 3'd3,
    RSEL_POL    = 3'd4,
    RSEL_TRIG   = 3'd5,
    RSEL_MASKED = 3'd6,
    RSEL_VECCFG = 3'd7
  } rdSel_e;

  typedef struct packed {
    logic   wrStatus;
    logic   wrEnable;
    logic   wrClass;
    logic   wrPol;
    logic   wrTrig;
    logic   wrVecCfg;
    logic   rdEn;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irqSync.sv
module irqSync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;

endmodule

// File: rtl/irqCtrl.sv
module irqCtrl
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] OFF_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_ENABLE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_CLASS  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_POL    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_TRIG   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] OFF_MASKED = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFF_VEC    = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] OFF_VECCFG = ADDR_W'(8);

  always_comb begin
    strobe = '0;
    strobe.rdEn = busRd;
    case (busAddr)
      OFF_STATUS: begin strobe.wrStatus = busWr; strobe.rdSel = RSEL_STATUS; end
      OFF_ENABLE: begin strobe.wrEnable = busWr; strobe.rdSel = RSEL_ENABLE; end
      OFF_CLASS:  begin strobe.wrClass  = busWr; strobe.rdSel = RSEL_CLASS;  end
      OFF_POL:    begin strobe.wrPol    = busWr; strobe.rdSel = RSEL_POL;    end
      OFF_TRIG:   begin strobe.wrTrig   = busWr; strobe.rdSel = RSEL_TRIG;   end
      OFF_MASKED: begin strobe.rdSel    = RSEL_MASKED; end
      OFF_VEC:    begin strobe.rdSel    = RSEL_NONE;   end
      OFF_VECCFG: begin strobe.wrVecCfg = busWr; strobe.rdSel = RSEL_VECCFG; end
      default:    begin strobe.rdSel    = RSEL_NONE;   end
    endcase
  end

endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqIn,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqNonCrit,
  output logic               irqCrit
);

  localparam logic [NUM_SRC-1:0] POL_RST = '1;

  logic [NUM_SRC-1:0] inBits;
  logic [NUM_SRC-1:0] syncBits;
  logic [NUM_SRC-1:0] prevBits;
  logic [NUM_SRC-1:0] statusReg;
  logic [NUM_SRC-1:0] enableReg;
  logic [NUM_SRC-1:0] classReg;
  logic [NUM_SRC-1:0] polReg;
  logic [NUM_SRC-1:0] trigReg;
  logic [DATA_W-1:0]  vecCfgReg;
  logic [NUM_SRC-1:0] wrBits;
  logic [NUM_SRC-1:0] activeLvl;
  logic [NUM_SRC-1:0] riseEv;
  logic [NUM_SRC-1:0] fallEv;
  logic [NUM_SRC-1:0] edgeEv;
  logic [NUM_SRC-1:0] levelEv;
  logic [NUM_SRC-1:0] setEv;
  logic [NUM_SRC-1:0] clrReq;
  logic [NUM_SRC-1:0] maskedBits;
  logic [DATA_W-1:0]  rdVal;

  // Source n lands on register bit NUM_SRC-1-n.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_bitmap
    assign inBits[NUM_SRC-1-n] = irqIn[n];
  end

  irqSync #(.WIDTH(NUM_SRC)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (inBits),
    .syncOut (syncBits)
  );

  assign wrBits    = wrData[NUM_SRC-1:0];
  assign activeLvl = ~(syncBits ^ polReg);
  // Edges compare raw synchronised samples, so a polarity write alone
  // never looks like a transition.
  assign riseEv    = syncBits & ~prevBits;
  assign fallEv    = ~syncBits & prevBits;
  assign edgeEv    = trigReg & ((polReg & riseEv) | (~polReg & fallEv));
  assign levelEv   = ~trigReg & activeLvl;
  assign setEv     = edgeEv | levelEv;
  assign clrReq    = strobe.wrStatus ? wrBits : '0;
  assign maskedBits = statusReg & enableReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevBits  <= '0;
      statusReg <= '0;
      enableReg <= '0;
      classReg  <= '0;
      polReg    <= POL_RST;
      trigReg   <= '0;
      vecCfgReg <= '0;
    end else begin
      prevBits  <= syncBits;
      statusReg <= setEv | (statusReg & ~clrReq);
      if (strobe.wrEnable) enableReg <= wrBits;
      if (strobe.wrClass)  classReg  <= wrBits;
      if (strobe.wrPol)    polReg    <= wrBits;
      if (strobe.wrTrig)   trigReg   <= wrBits;
      if (strobe.wrVecCfg) vecCfgReg <= wrData;
    end
  end

  assign irqNonCrit = |(maskedBits & ~classReg);
  assign irqCrit    = |(maskedBits & classReg);

  always_comb begin
    case (strobe.rdSel)
      RSEL_STATUS: rdVal = DATA_W'(statusReg);
      RSEL_ENABLE: rdVal = DATA_W'(enableReg);
      RSEL_CLASS:  rdVal = DATA_W'(classReg);
      RSEL_POL:    rdVal = DATA_W'(polReg);
      RSEL_TRIG:   rdVal = DATA_W'(trigReg);
      RSEL_MASKED: rdVal = DATA_W'(maskedBits);
      RSEL_VECCFG: rdVal = vecCfgReg;
      default:     rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strobe.rdEn) begin
      rdData <= rdVal;
    end
  end

  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (levelEv != '0) |=> ((statusReg & $past(levelEv)) == $past(levelEv)));

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.wrStatus |=> ((statusReg & $past(wrBits & ~setEv)) == '0));

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (((statusReg & trigReg) != '0) && !strobe.wrStatus)
      |=> ((statusReg & $past(statusReg & trigReg)) == $past(statusReg & trigReg)));

  // R8
  crit_src_chk: assert property (@(posedge clk) disable iff (rst)
    irqCrit |-> ((statusReg & enableReg & classReg) != '0));

  // R8
  noncrit_src_chk: assert property (@(posedge clk) disable iff (rst)
    irqNonCrit |-> ((statusReg & enableReg & ~classReg) != '0));

  // R7
  masked_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdEn && strobe.rdSel == RSEL_MASKED)
      |=> ((rdData[NUM_SRC-1:0] & ~$past(statusReg)) == '0));

  // R11
  vec_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdEn && strobe.rdSel == RSEL_NONE) |=> (rdData == '0));

endmodule

// File: rtl/irqCtrlTop.sv
module irqCtrlTop
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busWr,
  input  logic               busRd,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqNonCrit,
  output logic               irqCrit
);

  regStrobe_t strobe;

  irqCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strobe  (strobe)
  );

  irqDatapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .irqIn      (irqIn),
    .strobe     (strobe),
    .wrData     (busWrData),
    .rdData     (busRdData),
    .irqNonCrit (irqNonCrit),
    .irqCrit    (irqCrit)
  );

endmodule

// File: tb/tb_irqCtrlTop.sv
module tb_irqCtrlTop;

  localparam int NS = 32;
  localparam logic [3:0] A_STAT = 4'h0, A_EN = 4'h2, A_CLS = 4'h3, A_POL = 4'h4,
                         A_TRIG = 4'h5, A_MSK = 4'h6, A_VEC = 4'h7, A_VCFG = 4'h8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irqIn = '0;
  logic [3:0]    busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic          busWr = 1'b0;
  logic          busRd = 1'b0;
  logic [31:0]   busRdData;
  logic          irqNonCrit;
  logic          irqCrit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  irqCtrlTop dut (
    .clk(clk), .rst(rst), .irqIn(irqIn), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .irqNonCrit(irqNonCrit), .irqCrit(irqCrit)
  );

  function automatic logic [31:0] bitOf(int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic regRead(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    waitClk(3);
    rst = 1'b0;
    waitClk(1);

    // R2 reset state
    regRead(A_EN, v);   check("R2 enable", v, 32'h0);
    regRead(A_CLS, v);  check("R2 class", v, 32'h0);
    regRead(A_TRIG, v); check("R2 trigger", v, 32'h0);
    regRead(A_POL, v);  check("R2 polarity", v, 32'hFFFF_FFFF);
    regRead(A_STAT, v); check("R2 pending", v, 32'h0);
    regRead(A_VCFG, v); check("R2 storage", v, 32'h0);
    check("R2 outputs", {30'h0, irqCrit, irqNonCrit}, 32'h0);

    // R10 readback
    regWrite(A_CLS, 32'hA5A5_0F0F); regRead(A_CLS, v); check("R10 class rb", v, 32'hA5A5_0F0F);
    regWrite(A_CLS, 32'h0);

    // R3 R6 R1 level-high sweep, sources disabled
    for (int n = 0; n < NS; n++) begin
      irqIn[n] = 1'b1;
      waitClk(3);
      regRead(A_STAT, v); check("R1 R3 level-high set", v, bitOf(n));
      regRead(A_MSK, v);  check("R7 masked while disabled", v, 32'h0);
      regWrite(A_STAT, 32'hFFFF_FFFF);
      regRead(A_STAT, v); check("R6 clear blocked", v, bitOf(n));
      irqIn[n] = 1'b0;
      waitClk(3);
      regWrite(A_STAT, bitOf(n));
      regRead(A_STAT, v); check("R5 level clear after release", v, 32'h0);
    end

    // R6 blocked clear also while enabled
    regWrite(A_EN, bitOf(9));
    irqIn[9] = 1'b1; waitClk(3);
    regWrite(A_STAT, bitOf(9));
    regRead(A_STAT, v); check("R6 clear blocked enabled", v, bitOf(9));
    irqIn[9] = 1'b0; waitClk(3);
    regWrite(A_STAT, 32'hFFFF_FFFF);
    regWrite(A_EN, 32'h0);

    // R4 R5 rising-edge sweep
    regWrite(A_TRIG, 32'hFFFF_FFFF);
    regRead(A_TRIG, v); check("R10 trigger rb", v, 32'hFFFF_FFFF);
    for (int n = 0; n < NS; n++) begin
      irqIn[n] = 1'b1;
      waitClk(3);
      regRead(A_STAT, v); check("R4 rising set", v, bitOf(n));
      regWrite(A_STAT, bitOf(n));
      regRead(A_STAT, v); check("R5 edge clear while held", v, 32'h0);
      irqIn[n] = 1'b0;
      waitClk(3);
      regRead(A_STAT, v); check("R4 no event on falling", v, 32'h0);
    end

    // R12 polarity write with steady low inputs
    regWrite(A_POL, 32'h0); waitClk(3);
    regRead(A_STAT, v); check("R12 pol write no edge", v, 32'h0);
    regRead(A_POL, v);  check("R10 polarity rb", v, 32'h0);
    regWrite(A_POL, 32'hFFFF_FFFF); waitClk(3);
    regRead(A_STAT, v); check("R12 pol restore no edge", v, 32'h0);

    // R4 falling-edge sweep
    irqIn = '1; waitClk(3);
    regRead(A_STAT, v); check("R4 all rising", v, 32'hFFFF_FFFF);
    regWrite(A_STAT, 32'h0);
    regRead(A_STAT, v); check("R5 zero write keeps", v, 32'hFFFF_FFFF);
    regWrite(A_STAT, 32'hFFFF_FFFF);
    regWrite(A_POL, 32'h0); waitClk(3);
    regRead(A_STAT, v); check("R5 all clear", v, 32'h0);
    for (int n = 0; n < NS; n++) begin
      irqIn[n] = 1'b0;
      waitClk(3);
      regRead(A_STAT, v); check("R4 falling set", v, bitOf(n));
      irqIn[n] = 1'b1;
      waitClk(3);
      regRead(A_STAT, v); check("R4 held after rise", v, bitOf(n));
      regWrite(A_STAT, bitOf(n));
    end

    // R3 level-low sweep (inputs idle high)
    regWrite(A_TRIG, 32'h0);
    regWrite(A_STAT, 32'hFFFF_FFFF);
    regRead(A_STAT, v); check("R3 level-low idle", v, 32'h0);
    for (int n = 0; n < NS; n++) begin
      irqIn[n] = 1'b0;
      waitClk(3);
      regRead(A_STAT, v); check("R3 level-low set", v, bitOf(n));
      irqIn[n] = 1'b1;
      waitClk(3);
      regWrite(A_STAT, bitOf(n));
    end
    regWrite(A_POL, 32'hFFFF_FFFF);
    irqIn = '0; waitClk(3);
    regWrite(A_STAT, 32'hFFFF_FFFF);

    // R7 R8 steering sweep, level-high
    for (int n = 0; n < NS; n++) begin
      irqIn[n] = 1'b1; waitClk(3);
      check("R7 disabled no output", {30'h0, irqCrit, irqNonCrit}, 32'h0);
      regWrite(A_EN, bitOf(n));
      regRead(A_MSK, v); check("R7 masked", v, bitOf(n));
      check("R8 normal class", {30'h0, irqCrit, irqNonCrit}, 32'h1);
      regWrite(A_CLS, bitOf(n));
      check("R8 critical class", {30'h0, irqCrit, irqNonCrit}, 32'h2);
      regWrite(A_CLS, ~bitOf(n));
      check("R8 other class bits", {30'h0, irqCrit, irqNonCrit}, 32'h1);
      regWrite(A_EN, ~bitOf(n));
      regRead(A_MSK, v); check("R7 other enables", v, 32'h0);
      irqIn[n] = 1'b0; waitClk(3);
      regWrite(A_STAT, 32'hFFFF_FFFF);
      regWrite(A_EN, 32'h0);
      regWrite(A_CLS, 32'h0);
    end

    // R9 latency at outputs
    regWrite(A_EN, bitOf(17));
    @(negedge clk); irqIn[17] = 1'b1;
    waitClk(2);
    check("R9 not before k+2", {31'h0, irqNonCrit}, 32'h0);
    waitClk(1);
    check("R9 at k+2", {31'h0, irqNonCrit}, 32'h1);
    irqIn[17] = 1'b0; waitClk(3);
    regWrite(A_STAT, 32'hFFFF_FFFF);
    regWrite(A_EN, 32'h0);

    // R11 storage and zero offsets
    regWrite(A_VCFG, 32'hDEAD_BEEF);
    regRead(A_VCFG, v); check("R11 storage rb", v, 32'hDEAD_BEEF);
    regWrite(A_VEC, 32'h1234_5678);
    regRead(A_VEC, v);  check("R11 vector zero", v, 32'h0);
    regRead(4'h1, v);   check("R11 unmapped 1", v, 32'h0);
    regRead(4'hC, v);   check("R11 unmapped C", v, 32'h0);
    regRead(A_VCFG, v); check("R11 storage kept", v, 32'hDEAD_BEEF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule